// File: doc/BRIEF.md
# Size-Selectable Logic and Compare Unit

This block is the purely combinational execute stage for the bit-manipulation, bitwise, shift, rotate, population-count and compare instructions of a 64-bit register machine. In one evaluation it takes an opcode, a 2-bit operand-size code, the destination operand, the source operand and the current flags word. It returns the new destination value, the new flags word and a destination write-enable. Operand fetch, register storage and branching stay outside the block. The surrounding pipeline writes `dstOut` back when `dstWrEn` is high and always takes `flagsOut` as the next flags word.

A single 64-bit datapath serves all four operand sizes. Sized operations act on the low 8, 16, 32 or 64 bits and leave the bits above that width untouched. The zero test and the compares instead write a 0/1 value across the whole 64-bit destination. Two operations act on the flags word. The zero test drives the EQUAL flag, and the bit test writes a flag bit chosen by the source operand.

Top module: `sized_logic_unit`

## Requirements
- R1: Size code 00/01/10/11 selects an operand width W of 8/16/32/64 bits. For bit set, bit clear, AND, OR, XOR, shifts, rotates and population count, destination bits at W and above leave the unit unchanged.
- R2: Opcode 0x020 sets destination bit (src mod W) and opcode 0x021 clears it. All other bits keep their value.
- R3: Opcode 0x022 takes k = src mod W and writes flags bit k as the XOR of flags bit k and destination bit k. All other flag bits are kept and `dstWrEn` is low.
- R4: Opcode 0x024 checks the low W destination bits. If they are all zero, the full destination becomes 1 and flags bit 0 (EQUAL) is set. Otherwise the destination becomes 0 and EQUAL is cleared.
- R5: Opcodes 0x025, 0x026 and 0x027 put the AND, OR and XOR of destination and source into the low W bits.
- R6: Opcode 0x028 shifts the sized destination left and 0x029 shifts it right, both logically, by the full 64-bit source amount. Any amount of W or more gives 0.
- R7: Opcode 0x02A is an arithmetic right shift at width W that fills with bit W-1. Any amount of W or more gives W copies of that bit.
- R8: Opcode 0x02B rotates the sized destination left and 0x02C rotates it right, by (src mod W). An amount of 0 or a multiple of W leaves the value unchanged.
- R9: Opcode 0x02D replaces the low W destination bits with the number of one bits among them. The source is ignored.
- R10: Opcodes 0x030 to 0x035 evaluate EQ, NE, GT, GE, LT and LE of destination against source, with both operands taken as signed W-bit values. They write 1 (true) or 0 (false) to the full 64-bit destination.
- R11: Any other opcode drives `dstWrEn` low and passes the destination and the flags through unchanged.
- R12: All supported opcodes except 0x022 drive `dstWrEn` high. All opcodes except 0x022 and 0x024 leave the flags word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 10 | Operation code |
| sizeCode | input | 2 | Operand width select (00=8, 01=16, 10=32, 11=64) |
| dstIn | input | 64 | Destination operand |
| srcIn | input | 64 | Source operand, bit index or shift/rotate amount |
| flagsIn | input | 64 | Current flags word, bit 0 is EQUAL |
| dstOut | output | 64 | New destination value |
| flagsOut | output | 64 | New flags word |
| dstWrEn | output | 1 | Destination write-enable |

## Verification
The hardest cases to reach are the ones where the narrow view and the full 64-bit view of an operand disagree. Examples are a destination that is zero in its low byte but not above it, a shift amount whose low bits are small while the full value exceeds W, and operands that compare equal at 8 bits but differ at 64. The stimulus sweeps every size with dense patterns chosen for this purpose (upper-half-only values, sign-boundary values, 0x...7F/0x...80 edges). It also sweeps every shift and rotate amount from 0 to W+2, plus one amount above 2^32 whose low bits are 3.

// File: rtl/lcu_pkg.sv
package lcu_pkg;
  localparam int OP_W = 10;

  localparam logic [OP_W-1:0] OPC_BSET = 10'h020;
  localparam logic [OP_W-1:0] OPC_BCLR = 10'h021;
  localparam logic [OP_W-1:0] OPC_BTST = 10'h022;
  localparam logic [OP_W-1:0] OPC_ZTST = 10'h024;
  localparam logic [OP_W-1:0] OPC_AND  = 10'h025;
  localparam logic [OP_W-1:0] OPC_OR   = 10'h026;
  localparam logic [OP_W-1:0] OPC_XOR  = 10'h027;
  localparam logic [OP_W-1:0] OPC_SHL  = 10'h028;
  localparam logic [OP_W-1:0] OPC_SHR  = 10'h029;
  localparam logic [OP_W-1:0] OPC_SAR  = 10'h02A;
  localparam logic [OP_W-1:0] OPC_ROL  = 10'h02B;
  localparam logic [OP_W-1:0] OPC_ROR  = 10'h02C;
  localparam logic [OP_W-1:0] OPC_POPC = 10'h02D;
  localparam logic [OP_W-1:0] OPC_CEQ  = 10'h030;
  localparam logic [OP_W-1:0] OPC_CNE  = 10'h031;
  localparam logic [OP_W-1:0] OPC_CGT  = 10'h032;
  localparam logic [OP_W-1:0] OPC_CGE  = 10'h033;
  localparam logic [OP_W-1:0] OPC_CLT  = 10'h034;
  localparam logic [OP_W-1:0] OPC_CLE  = 10'h035;

  typedef enum logic [3:0] {
    FN_NONE, FN_BSET, FN_BCLR, FN_BTST, FN_ZTST, FN_AND, FN_OR, FN_XOR,
    FN_SHL, FN_SHR, FN_SAR, FN_ROL, FN_ROR, FN_POPC, FN_CMP
  } fn_e;

  typedef enum logic [2:0] {
    CMP_EQ, CMP_NE, CMP_GT, CMP_GE, CMP_LT, CMP_LE
  } cmp_e;

  typedef struct packed {
    fn_e  fn;
    cmp_e cmp;
    logic dstWr;
    logic sizedMerge;
    logic fullWrite;
  } strobe_t;
endpackage

// File: rtl/lcu_ctrl.sv
module lcu_ctrl
  import lcu_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output strobe_t         stb
);
  always_comb begin
    stb = '{fn: FN_NONE, cmp: CMP_EQ, dstWr: 1'b0, sizedMerge: 1'b0, fullWrite: 1'b0};
    case (opcode)
      OPC_BSET: stb.fn = FN_BSET;
      OPC_BCLR: stb.fn = FN_BCLR;
      OPC_BTST: stb.fn = FN_BTST;
      OPC_ZTST: stb.fn = FN_ZTST;
      OPC_AND:  stb.fn = FN_AND;
      OPC_OR:   stb.fn = FN_OR;
      OPC_XOR:  stb.fn = FN_XOR;
      OPC_SHL:  stb.fn = FN_SHL;
      OPC_SHR:  stb.fn = FN_SHR;
      OPC_SAR:  stb.fn = FN_SAR;
      OPC_ROL:  stb.fn = FN_ROL;
      OPC_ROR:  stb.fn = FN_ROR;
      OPC_POPC: stb.fn = FN_POPC;
      OPC_CEQ:  begin stb.fn = FN_CMP; stb.cmp = CMP_EQ; end
      OPC_CNE:  begin stb.fn = FN_CMP; stb.cmp = CMP_NE; end
      OPC_CGT:  begin stb.fn = FN_CMP; stb.cmp = CMP_GT; end
      OPC_CGE:  begin stb.fn = FN_CMP; stb.cmp = CMP_GE; end
      OPC_CLT:  begin stb.fn = FN_CMP; stb.cmp = CMP_LT; end
      OPC_CLE:  begin stb.fn = FN_CMP; stb.cmp = CMP_LE; end
      default:  stb.fn = FN_NONE;
    endcase
    case (stb.fn)
      FN_NONE, FN_BTST: ;
      FN_ZTST, FN_CMP: begin stb.dstWr = 1'b1; stb.fullWrite = 1'b1; end
      default: begin stb.dstWr = 1'b1; stb.sizedMerge = 1'b1; end
    endcase
  end
endmodule

// File: rtl/lcu_dpath.sv
module lcu_dpath
  import lcu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int EQ_BIT = 0
) (
  input  strobe_t           stb,
  input  logic [1:0]        sizeCode,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] flagsIn,
  output logic [DATA_W-1:0] dstOut,
  output logic [DATA_W-1:0] flagsOut
);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int NUM_SZ  = 4;

  logic [DATA_W-1:0] maskTab [NUM_SZ];

  // One width mask per size code; the widest size covers the whole word.
  for (genvar g = 0; g < NUM_SZ; g++) begin : gen_mask
    if ((8 << g) >= DATA_W) begin : gen_full
      assign maskTab[g] = '1;
    end else begin : gen_part
      assign maskTab[g] = (DATA_W'(1) << (8 << g)) - DATA_W'(1);
    end
  end

  logic [IDX_W:0]    widthV;
  logic [DATA_W-1:0] mask, dSz, sSz, dExt, sExt, oneHot, res;
  logic [IDX_W-1:0]  bitIdx;
  logic              dSign, sSign, bigAmt, eqV, ltV, cmpV;

  always_comb begin
    widthV = (IDX_W+1)'(8) << sizeCode;
    mask   = maskTab[sizeCode];
    dSz    = dstIn & mask;
    sSz    = srcIn & mask;
    dSign  = |(dSz & (mask ^ (mask >> 1)));
    sSign  = |(sSz & (mask ^ (mask >> 1)));
    dExt   = dSign ? (dSz | ~mask) : dSz;
    sExt   = sSign ? (sSz | ~mask) : sSz;
    bitIdx = srcIn[IDX_W-1:0] & IDX_W'(widthV - (IDX_W+1)'(1));
    oneHot = DATA_W'(1) << bitIdx;
    bigAmt = srcIn >= DATA_W'(widthV);
    eqV    = (dSz == sSz);
    ltV    = $signed(dExt) < $signed(sExt);

    case (stb.cmp)
      CMP_EQ:  cmpV = eqV;
      CMP_NE:  cmpV = !eqV;
      CMP_GT:  cmpV = !ltV && !eqV;
      CMP_GE:  cmpV = !ltV;
      CMP_LT:  cmpV = ltV;
      default: cmpV = ltV || eqV;
    endcase

    case (stb.fn)
      FN_BSET: res = dSz | oneHot;
      FN_BCLR: res = dSz & ~oneHot;
      FN_ZTST: res = DATA_W'(dSz == '0);
      FN_AND:  res = dSz & sSz;
      FN_OR:   res = dSz | sSz;
      FN_XOR:  res = dSz ^ sSz;
      FN_SHL:  res = bigAmt ? '0 : (dSz << srcIn[IDX_W-1:0]);
      FN_SHR:  res = bigAmt ? '0 : (dSz >> srcIn[IDX_W-1:0]);
      FN_SAR:  res = bigAmt ? (dSign ? mask : '0)
                            : DATA_W'($signed(dExt) >>> srcIn[IDX_W-1:0]);
      FN_ROL:  res = (dSz << bitIdx) | (dSz >> (widthV - {1'b0, bitIdx}));
      FN_ROR:  res = (dSz >> bitIdx) | (dSz << (widthV - {1'b0, bitIdx}));
      FN_POPC: res = DATA_W'($countones(dSz));
      FN_CMP:  res = DATA_W'(cmpV);
      default: res = dstIn;
    endcase

    if (stb.sizedMerge)     dstOut = (dstIn & ~mask) | (res & mask);
    else if (stb.fullWrite) dstOut = res;
    else                    dstOut = dstIn;

    flagsOut = flagsIn;
    if (stb.fn == FN_BTST) flagsOut[bitIdx] = flagsIn[bitIdx] ^ dstIn[bitIdx];
    else if (stb.fn == FN_ZTST) flagsOut[EQ_BIT] = (dSz == '0);
  end
endmodule

// File: rtl/sized_logic_unit.sv
module sized_logic_unit
  import lcu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int EQ_BIT = 0
) (
  input  logic [OP_W-1:0]   opcode,
  input  logic [1:0]        sizeCode,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] flagsIn,
  output logic [DATA_W-1:0] dstOut,
  output logic [DATA_W-1:0] flagsOut,
  output logic              dstWrEn
);
  strobe_t stb;

  lcu_ctrl u_ctrl (.opcode(opcode), .stb(stb));

  lcu_dpath #(.DATA_W(DATA_W), .EQ_BIT(EQ_BIT)) u_dpath (
    .stb(stb), .sizeCode(sizeCode), .dstIn(dstIn), .srcIn(srcIn),
    .flagsIn(flagsIn), .dstOut(dstOut), .flagsOut(flagsOut)
  );

  assign dstWrEn = stb.dstWr;
endmodule

// File: rtl/lcu_checker.sv
module lcu_checker
  import lcu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int EQ_BIT = 0
) (
  input logic [OP_W-1:0]   opcode,
  input logic [1:0]        sizeCode,
  input logic [DATA_W-1:0] dstIn,
  input logic [DATA_W-1:0] srcIn,
  input logic [DATA_W-1:0] flagsIn,
  input logic [DATA_W-1:0] dstOut,
  input logic [DATA_W-1:0] flagsOut,
  input logic              dstWrEn
);
  logic [DATA_W-1:0] upMask;
  logic isSized, isCmp, isKnown, isFlagOp;

  always_comb begin
    upMask = '1;
    for (int b = 0; b < DATA_W; b++)
      if (b < (8 << sizeCode)) upMask[b] = 1'b0;
    isSized  = (opcode == OPC_BSET) || (opcode == OPC_BCLR) ||
               ((opcode >= OPC_AND) && (opcode <= OPC_POPC));
    isCmp    = (opcode >= OPC_CEQ) && (opcode <= OPC_CLE);
    isFlagOp = (opcode == OPC_BTST) || (opcode == OPC_ZTST);
    isKnown  = isSized || isCmp || isFlagOp;
  end

  always_comb begin
    if (isSized)
      assert_upper_kept_R1: assert ((dstOut & upMask) == (dstIn & upMask))
        else $error("upper destination bits changed");
    if (opcode == OPC_BTST)
      assert_btest_one_flag_R3: assert (!dstWrEn && $countones(flagsOut ^ flagsIn) <= 1)
        else $error("bit test wrote destination or several flags");
    if (opcode == OPC_ZTST)
      assert_zero_flag_match_R4: assert (flagsOut[EQ_BIT] == dstOut[0] && dstOut[DATA_W-1:1] == '0)
        else $error("zero test flag and result disagree");
    if (isCmp)
      assert_cmp_boolean_R10: assert (dstWrEn && dstOut[DATA_W-1:1] == '0)
        else $error("compare result not 0/1");
    if (!isKnown)
      assert_unknown_inert_R11: assert (!dstWrEn && flagsOut == flagsIn && dstOut == dstIn)
        else $error("unsupported opcode had an effect");
    if (!isFlagOp)
      assert_flags_kept_R12: assert (flagsOut == flagsIn)
        else $error("flags changed by a non-flag op");
  end
endmodule

bind sized_logic_unit lcu_checker #(.DATA_W(DATA_W), .EQ_BIT(EQ_BIT)) u_chk (.*);

// File: tb/sized_logic_unit_test.sv
module sized_logic_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  opcode = '0;
  logic [1:0]  sizeCode = '0;
  logic [63:0] dstIn = '0, srcIn = '0, flagsIn = '0;
  logic [63:0] dstOut, flagsOut;
  logic        dstWrEn;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sized_logic_unit uut (
    .opcode(opcode), .sizeCode(sizeCode), .dstIn(dstIn), .srcIn(srcIn),
    .flagsIn(flagsIn), .dstOut(dstOut), .flagsOut(flagsOut), .dstWrEn(dstWrEn)
  );

  logic [63:0] pat [8];
  initial begin
    pat[0] = 64'h0;
    pat[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pat[2] = 64'h0123_4567_89AB_CDEF;
    pat[3] = 64'h8000_0000_8000_8080;
    pat[4] = 64'h7FFF_FFFF_7FFF_7F7F;
    pat[5] = 64'hA5A5_0000_5A5A_00FF;
    pat[6] = 64'h1;
    pat[7] = 64'hDEAD_BEEF_0000_0000;
  end

  function automatic string reqOf(input logic [9:0] op);
    case (op)
      10'h020, 10'h021: return "R2";
      10'h022: return "R3";
      10'h024: return "R4";
      10'h025, 10'h026, 10'h027: return "R5";
      10'h028, 10'h029: return "R6";
      10'h02A: return "R7";
      10'h02B, 10'h02C: return "R8";
      10'h02D: return "R9";
      10'h030, 10'h031, 10'h032, 10'h033, 10'h034, 10'h035: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic longint sext(input logic [63:0] v, input int w);
    logic [63:0] r = v;
    for (int i = w; i < 64; i++) r[i] = v[w-1];
    return longint'(r);
  endfunction

  task automatic model(input logic [9:0] op, input logic [1:0] sz,
                       input logic [63:0] d, input logic [63:0] s, input logic [63:0] f,
                       output logic [63:0] nd, output logic [63:0] nf, output logic we);
    int w = 8 << sz;
    int bi = int'(s % 64'(w));
    int sh = (s >= 64'(w)) ? w : int'(s);
    logic zero;
    logic [63:0] tmp;
    longint a, b;
    int cnt;
    nd = d; nf = f; we = 1'b1;
    a = sext(d, w); b = sext(s, w);
    case (op)
      10'h020: nd[bi] = 1'b1;
      10'h021: nd[bi] = 1'b0;
      10'h022: begin nf[bi] = f[bi] ^ d[bi]; we = 1'b0; end
      10'h024: begin
        zero = 1'b1;
        for (int i = 0; i < w; i++) if (d[i]) zero = 1'b0;
        nd = {63'b0, zero}; nf[0] = zero;
      end
      10'h025: for (int i = 0; i < w; i++) nd[i] = d[i] & s[i];
      10'h026: for (int i = 0; i < w; i++) nd[i] = d[i] | s[i];
      10'h027: for (int i = 0; i < w; i++) nd[i] = d[i] ^ s[i];
      10'h028: for (int i = 0; i < w; i++) nd[i] = (i >= sh) ? d[i-sh] : 1'b0;
      10'h029: for (int i = 0; i < w; i++) nd[i] = (i + sh < w) ? d[i+sh] : 1'b0;
      10'h02A: for (int i = 0; i < w; i++) nd[i] = (i + sh < w) ? d[i+sh] : d[w-1];
      10'h02B: begin
        tmp = d;
        for (int i = 0; i < w; i++) tmp[(i + bi) % w] = d[i];
        for (int i = 0; i < w; i++) nd[i] = tmp[i];
      end
      10'h02C: for (int i = 0; i < w; i++) nd[i] = d[(i + bi) % w];
      10'h02D: begin
        cnt = 0;
        for (int i = 0; i < w; i++) cnt += int'(d[i]);
        for (int i = 0; i < w; i++) nd[i] = (i < 32) ? cnt[i] : 1'b0;
      end
      10'h030: nd = {63'b0, a == b};
      10'h031: nd = {63'b0, a != b};
      10'h032: nd = {63'b0, a >  b};
      10'h033: nd = {63'b0, a >= b};
      10'h034: nd = {63'b0, a <  b};
      10'h035: nd = {63'b0, a <= b};
      default: we = 1'b0;
    endcase
  endtask

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [9:0] op, input logic [1:0] sz,
                       input logic [63:0] d, input logic [63:0] s, input logic [63:0] f);
    logic [63:0] nd, nf, upper;
    logic we;
    string fr;
    @(posedge clk);
    opcode = op; sizeCode = sz; dstIn = d; srcIn = s; flagsIn = f;
    model(op, sz, d, s, f, nd, nf, we);
    @(negedge clk);
    check(dstOut == nd, reqOf(op), "dst", dstOut, nd);
    fr = (op == 10'h022) ? "R3" : (op == 10'h024) ? "R4" : "R12";
    check(flagsOut == nf, fr, "flags", flagsOut, nf);
    check(dstWrEn == we, (reqOf(op) == "R11") ? "R11" : "R12", "wrEn",
          {63'b0, dstWrEn}, {63'b0, we});
    if (sz != 2'b11 && (op == 10'h020 || op == 10'h021 ||
                        (op >= 10'h025 && op <= 10'h02D))) begin
      upper = 64'hFFFF_FFFF_FFFF_FFFF << (8 << sz);
      check((dstOut & upper) == (d & upper), "R1", "upper bits",
            dstOut & upper, d & upper);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  logic [9:0] amtOps [8];
  logic [9:0] dataOps [11];
  logic [9:0] badOps [7];

  initial begin
    amtOps  = '{10'h020, 10'h021, 10'h022, 10'h028, 10'h029, 10'h02A, 10'h02B, 10'h02C};
    dataOps = '{10'h024, 10'h025, 10'h026, 10'h027, 10'h02D,
                10'h030, 10'h031, 10'h032, 10'h033, 10'h034, 10'h035};
    badOps  = '{10'h000, 10'h01F, 10'h023, 10'h02E, 10'h02F, 10'h036, 10'h3FF};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: idle opcode 0 after reset writes nothing
    check(dstWrEn == 1'b0, "R11", "reset wrEn", {63'b0, dstWrEn}, 64'h0);
    check(flagsOut == flagsIn, "R11", "reset flags", flagsOut, flagsIn);

    for (int sz = 0; sz < 4; sz++) begin
      for (int oi = 0; oi < 8; oi++)
        for (int di = 0; di < 8; di++) begin
          for (int s = 0; s <= (8 << sz) + 2; s++)
            apply(amtOps[oi], 2'(sz), pat[di], 64'(s), pat[(di + s) % 8]);
          // R6 R8: huge amount whose low bits are 3
          apply(amtOps[oi], 2'(sz), pat[di], 64'h1_0000_0003, pat[di]);
        end
      for (int oi = 0; oi < 11; oi++)
        for (int di = 0; di < 8; di++)
          for (int si = 0; si < 8; si++)
            apply(dataOps[oi], 2'(sz), pat[di], pat[si], pat[(di + si + 3) % 8]);
      for (int oi = 0; oi < 7; oi++)
        for (int di = 0; di < 8; di++)
          apply(badOps[oi], 2'(sz), pat[di], pat[7 - di], pat[(di + 5) % 8]);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule